// File: doc/BRIEF.md
# Battery-Backed SRAM Supply Guard

This controller sits between a host and a battery-backed static RAM and keeps the stored data intact while the main supply fails and returns. It takes already-synchronized comparator flags: supply below the protection threshold (one flag for a tight 5 % threshold and one for a wide 10 % threshold), supply below the battery switch level, and supply below the battery voltage. It also takes a slow timing tick. From these it blocks the host's chip, write and output enables. It picks the battery or the main rail for the array, turns the charger on and off, and drives an active-low processor reset in open-drain form.

One phase sequencer orders the whole cycle. A supply drop puts the block into a guarded phase. Once the supply is back, a recovery count keeps writes blocked. A longer count then keeps the reset held after access has reopened. A dip during either count restarts from the guarded phase. The battery stays disconnected until the supply first clears the threshold, and after that it stays enabled for backup.

The recovery and reset windows are parameters in tick counts. If the reset window is set no longer than the recovery window, it is stretched to one tick beyond the recovery window, so reset always releases after write protection.

Top module: `nvsram_pwr_guard`

## Requirements
- R1: One clock edge after the selected low-supply flag is seen high, `sram_ce_n_o`, `sram_we_n_o` and `sram_oe_n_o` are all 1 and `dq_drive_en_o` is 0. While protection lasts, host enable inputs have no effect on these outputs.
- R2: `tol_wide_i`=0 makes `cmp_trip_tight_i` the low-supply flag; `tol_wide_i`=1 makes `cmp_trip_wide_i` the flag. The unselected flag is ignored.
- R3: When the battery is enabled and `cmp_below_switch_i` is 1, `batt_sel_o` is 1 one edge later. When `cmp_below_switch_i` is 0, `batt_sel_o` is 0 one edge later.
- R4: After the low-supply flag clears with a tick on every cycle, protection is still in force after REC_TICKS+1 edges and is lifted at edge REC_TICKS+2. After that the SRAM enables follow the host enables.
- R5: `rst_pull_o`=1 means reset is driven low. It is 1 one edge after a low-supply flag while `cmp_below_batt_i` is 0. It is 0 one edge after `cmp_below_batt_i` is 1.
- R6: On recovery with a tick on every cycle, `rst_pull_o` stays 1 after RST_TICKS+1 edges and becomes 0 at edge RST_TICKS+2. Reset never releases while writes are still blocked.
- R7: `chg_en_o` is 1 one edge after the low-supply flag is 0, and 0 one edge after it is 1.
- R8: After reset `batt_armed_o` is 0 and the battery is never selected. It becomes 1 the first edge the low-supply flag is 0 and then stays 1.
- R9: A low-supply flag during the recovery or reset count clears the count and protection restarts. The full REC_TICKS+2 edges are needed after the next clear.
- R10: The counts advance only on cycles where `tick_i` is 1.
- R11: `dq_drive_en_o` is 1 exactly when host chip enable is low, host output enable is low, host write enable is high and protection is not in force.
- R12: `rst_lvl_o` is always 0; the reset pin is only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low controller reset |
| tol_wide_i | input | 1 | 0 selects the 5 % threshold flag, 1 the 10 % flag |
| cmp_trip_tight_i | input | 1 | Supply below 5 % threshold |
| cmp_trip_wide_i | input | 1 | Supply below 10 % threshold |
| cmp_below_switch_i | input | 1 | Supply below battery switch level |
| cmp_below_batt_i | input | 1 | Supply below battery voltage |
| tick_i | input | 1 | Timebase tick for the recovery and reset counts |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| sram_ce_n_o | output | 1 | Gated chip enable to the array |
| sram_we_n_o | output | 1 | Gated write enable to the array |
| sram_oe_n_o | output | 1 | Gated output enable to the array |
| dq_drive_en_o | output | 1 | Data bus output driver enable |
| batt_sel_o | output | 1 | 1 powers the array from the battery |
| batt_armed_o | output | 1 | Battery connected for backup |
| chg_en_o | output | 1 | Charger enable |
| rst_pull_o | output | 1 | Reset pull-down enable (reset active) |
| rst_lvl_o | output | 1 | Reset pin level when driven, always 0 |

## Verification
Every cycle, the assertions check that a low-supply flag blocks the enables and the charger on the next edge and clears the count. They also check that reset follows the flag and the battery comparator, that the battery is selected only after arming and tracks the switch comparator, that arming is sticky, and that reset never releases while protection holds. Only the bench scenarios show the exact length of the recovery and reset windows, that the counts freeze without ticks, that a dip restarts the full window, and how the threshold select chooses between the two flags.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

    typedef enum logic [1:0] {
        PH_GUARD   = 2'd0,
        PH_RECOVER = 2'd1,
        PH_HOLDRST = 2'd2,
        PH_ACTIVE  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   protect;
        logic   rst_pull;
    } seq_regs_t;

    typedef struct packed {
        logic armed;
        logic batt_sel;
        logic chg_en;
    } sup_regs_t;

endpackage

// File: rtl/nvg_tick_timer.sv
module nvg_tick_timer #(
    parameter int W     = 8,
    parameter int LIMIT = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] SAT = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q < SAT)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/nvg_phase_seq.sv
module nvg_phase_seq
    import nvg_pkg::*;
#(
    parameter int W        = 8,
    parameter int REC_LIM  = 10,
    parameter int RST_LIM  = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trip_i,
    input  logic         batt_low_i,
    input  logic         tick_i,
    input  logic [W-1:0] cnt_i,
    output logic         clr_o,
    output logic         inc_o,
    output logic         protect_o,
    output logic         rst_pull_o
);
    localparam logic [W-1:0] REC_CMP = W'(REC_LIM);
    localparam logic [W-1:0] RST_CMP = W'(RST_LIM);

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        clr_o = 1'b0;
        inc_o = 1'b0;
        if (trip_i) begin
            nxt_d.phase = PH_GUARD;
            clr_o       = 1'b1;
        end else begin
            case (cur_q.phase)
                PH_GUARD: begin
                    nxt_d.phase = PH_RECOVER;
                    clr_o       = 1'b1;
                end
                PH_RECOVER: begin
                    inc_o = tick_i;
                    if (cnt_i >= REC_CMP) begin
                        nxt_d.phase = PH_HOLDRST;
                    end
                end
                PH_HOLDRST: begin
                    inc_o = tick_i;
                    if (cnt_i >= RST_CMP) begin
                        nxt_d.phase = PH_ACTIVE;
                    end
                end
                default: begin
                    nxt_d.phase = PH_ACTIVE;
                end
            endcase
        end
        nxt_d.protect  = (nxt_d.phase == PH_GUARD) || (nxt_d.phase == PH_RECOVER);
        nxt_d.rst_pull = (nxt_d.phase != PH_ACTIVE) && !batt_low_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_GUARD, protect: 1'b1, rst_pull: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign protect_o  = cur_q.protect;
    assign rst_pull_o = cur_q.rst_pull;
endmodule

// File: rtl/nvg_supply_sel.sv
module nvg_supply_sel
    import nvg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic below_switch_i,
    output logic armed_o,
    output logic batt_sel_o,
    output logic chg_en_o
);
    sup_regs_t sup_q, sup_d;

    always_comb begin
        sup_d          = sup_q;
        sup_d.armed    = sup_q.armed || !trip_i;
        sup_d.batt_sel = sup_q.armed && below_switch_i;
        sup_d.chg_en   = !trip_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_q <= '0;
        end else begin
            sup_q <= sup_d;
        end
    end

    assign armed_o    = sup_q.armed;
    assign batt_sel_o = sup_q.batt_sel;
    assign chg_en_o   = sup_q.chg_en;
endmodule

// File: rtl/nvsram_pwr_guard.sv
module nvsram_pwr_guard #(
    parameter int REC_TICKS = 12,
    parameter int RST_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tol_wide_i,
    input  logic cmp_trip_tight_i,
    input  logic cmp_trip_wide_i,
    input  logic cmp_below_switch_i,
    input  logic cmp_below_batt_i,
    input  logic tick_i,
    input  logic host_ce_n_i,
    input  logic host_we_n_i,
    input  logic host_oe_n_i,
    output logic sram_ce_n_o,
    output logic sram_we_n_o,
    output logic sram_oe_n_o,
    output logic dq_drive_en_o,
    output logic batt_sel_o,
    output logic batt_armed_o,
    output logic chg_en_o,
    output logic rst_pull_o,
    output logic rst_lvl_o
);
    localparam int RST_EFF = (RST_TICKS > REC_TICKS) ? RST_TICKS : REC_TICKS + 1;
    localparam int CNT_W   = $clog2(RST_EFF + 2);

    logic             trip;
    logic             seq_protect;
    logic             tmr_clr;
    logic             tmr_inc;
    logic [CNT_W-1:0] tmr_cnt;

    assign trip = tol_wide_i ? cmp_trip_wide_i : cmp_trip_tight_i;

    nvg_tick_timer #(.W(CNT_W), .LIMIT(RST_EFF)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .cnt_o (tmr_cnt)
    );

    nvg_phase_seq #(.W(CNT_W), .REC_LIM(REC_TICKS), .RST_LIM(RST_EFF)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_i     (trip),
        .batt_low_i (cmp_below_batt_i),
        .tick_i     (tick_i),
        .cnt_i      (tmr_cnt),
        .clr_o      (tmr_clr),
        .inc_o      (tmr_inc),
        .protect_o  (seq_protect),
        .rst_pull_o (rst_pull_o)
    );

    nvg_supply_sel supply_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .trip_i         (trip),
        .below_switch_i (cmp_below_switch_i),
        .armed_o        (batt_armed_o),
        .batt_sel_o     (batt_sel_o),
        .chg_en_o       (chg_en_o)
    );

    assign sram_ce_n_o   = host_ce_n_i | seq_protect;
    assign sram_we_n_o   = host_we_n_i | seq_protect;
    assign sram_oe_n_o   = host_oe_n_i | seq_protect;
    assign dq_drive_en_o = !seq_protect && !host_ce_n_i && !host_oe_n_i && host_we_n_i;
    assign rst_lvl_o     = 1'b0;
endmodule

// File: rtl/nvg_guard_chk.sv
module nvg_guard_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tol_wide_i,
    input logic          cmp_trip_tight_i,
    input logic          cmp_trip_wide_i,
    input logic          cmp_below_switch_i,
    input logic          cmp_below_batt_i,
    input logic          sram_ce_n_o,
    input logic          sram_we_n_o,
    input logic          sram_oe_n_o,
    input logic          dq_drive_en_o,
    input logic          batt_sel_o,
    input logic          batt_armed_o,
    input logic          chg_en_o,
    input logic          rst_pull_o,
    input logic          protect,
    input logic [CW-1:0] cnt
);
    logic low_sup;
    assign low_sup = tol_wide_i ? cmp_trip_wide_i : cmp_trip_tight_i;

    // R1
    trip_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_sup |=> (sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !dq_drive_en_o));

    // R9
    trip_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_sup |=> (cnt == '0));

    // R7
    charger_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_sup |=> !chg_en_o);

    // R7
    charger_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !low_sup |=> chg_en_o);

    // R5
    reset_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_sup && !cmp_below_batt_i) |=> rst_pull_o);

    // R5
    reset_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_below_batt_i |=> !rst_pull_o);

    // R6
    reset_after_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_pull_o) && !$past(cmp_below_batt_i)) |-> !protect);

    // R3
    batt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_armed_o && cmp_below_switch_i) |=> batt_sel_o);

    // R3
    main_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_below_switch_i |=> !batt_sel_o);

    // R8
    batt_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel_o |-> $past(batt_armed_o));

    // R8
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        batt_armed_o |=> batt_armed_o);
endmodule

bind nvsram_pwr_guard nvg_guard_chk #(.CW(CNT_W)) guard_chk_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .tol_wide_i         (tol_wide_i),
    .cmp_trip_tight_i   (cmp_trip_tight_i),
    .cmp_trip_wide_i    (cmp_trip_wide_i),
    .cmp_below_switch_i (cmp_below_switch_i),
    .cmp_below_batt_i   (cmp_below_batt_i),
    .sram_ce_n_o        (sram_ce_n_o),
    .sram_we_n_o        (sram_we_n_o),
    .sram_oe_n_o        (sram_oe_n_o),
    .dq_drive_en_o      (dq_drive_en_o),
    .batt_sel_o         (batt_sel_o),
    .batt_armed_o       (batt_armed_o),
    .chg_en_o           (chg_en_o),
    .rst_pull_o         (rst_pull_o),
    .protect            (seq_protect),
    .cnt                (tmr_cnt)
);

// File: tb/nvsram_pwr_guard_tb_top.sv
module nvsram_pwr_guard_tb_top;
    localparam int REC = 12;
    localparam int RST = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tol_wide = 1'b0;
    logic trip_t = 1'b1;
    logic trip_w = 1'b1;
    logic below_sw = 1'b1;
    logic below_bat = 1'b1;
    logic tick = 1'b1;
    logic h_ce_n = 1'b0;
    logic h_we_n = 1'b0;
    logic h_oe_n = 1'b0;
    logic s_ce_n, s_we_n, s_oe_n, drv_en, b_sel, b_arm, chg, r_pull, r_lvl;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nvsram_pwr_guard #(.REC_TICKS(REC), .RST_TICKS(RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .tol_wide_i(tol_wide),
        .cmp_trip_tight_i(trip_t), .cmp_trip_wide_i(trip_w),
        .cmp_below_switch_i(below_sw), .cmp_below_batt_i(below_bat),
        .tick_i(tick), .host_ce_n_i(h_ce_n), .host_we_n_i(h_we_n),
        .host_oe_n_i(h_oe_n), .sram_ce_n_o(s_ce_n), .sram_we_n_o(s_we_n),
        .sram_oe_n_o(s_oe_n), .dq_drive_en_o(drv_en), .batt_sel_o(b_sel),
        .batt_armed_o(b_arm), .chg_en_o(chg), .rst_pull_o(r_pull),
        .rst_lvl_o(r_lvl)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        step(3);
        chk("R1", "ce blocked at reset", s_ce_n, 1);
        chk("R1", "we blocked at reset", s_we_n, 1);
        chk("R5", "reset floats below battery", r_pull, 0);
        chk("R8", "battery not armed", b_arm, 0);
        chk("R8", "battery not selected while unarmed", b_sel, 0);
        chk("R7", "charger off", chg, 0);
        chk("R12", "reset level", r_lvl, 0);
    endtask

    task automatic t_power_up();
        below_bat = 1'b0;
        step(1);
        chk("R5", "reset pulled above battery", r_pull, 1);
        below_sw = 1'b0;
        step(1);
        chk("R8", "main rail before arming", b_sel, 0);
        trip_t = 1'b0;
        trip_w = 1'b0;
        step(1);
        chk("R8", "armed on first good supply", b_arm, 1);
        chk("R7", "charger on", chg, 1);
        step(REC);
        chk("R4", "still protected at REC+1", s_ce_n, 1);
        step(1);
        chk("R4", "ce follows host at REC+2", s_ce_n, 0);
        chk("R4", "we follows host at REC+2", s_we_n, 0);
        chk("R6", "reset held after protection lifts", r_pull, 1);
        step(RST - REC - 1);
        chk("R6", "reset held at RST+1", r_pull, 1);
        step(1);
        chk("R6", "reset released at RST+2", r_pull, 0);
        chk("R12", "reset level in run", r_lvl, 0);
    endtask

    task automatic t_drive_enable();
        h_we_n = 1'b1; h_oe_n = 1'b0; h_ce_n = 1'b0;
        #1;
        chk("R11", "read drives bus", drv_en, 1);
        h_we_n = 1'b0;
        #1;
        chk("R11", "write disables driver", drv_en, 0);
        h_we_n = 1'b1; h_ce_n = 1'b1;
        #1;
        chk("R11", "deselect disables driver", drv_en, 0);
        h_ce_n = 1'b0; h_oe_n = 1'b1;
        #1;
        chk("R11", "oe high disables driver", drv_en, 0);
        h_oe_n = 1'b0;
        step(1);
    endtask

    task automatic t_power_fail();
        h_we_n = 1'b0;
        trip_t = 1'b1;
        step(1);
        chk("R1", "ce blocked", s_ce_n, 1);
        chk("R1", "we blocked", s_we_n, 1);
        chk("R1", "oe blocked", s_oe_n, 1);
        chk("R5", "reset pulled on trip", r_pull, 1);
        chk("R7", "charger off on trip", chg, 0);
        h_we_n = 1'b1;
        #1;
        chk("R1", "host read ignored, no drive", drv_en, 0);
        below_sw = 1'b1;
        step(1);
        chk("R3", "battery selected", b_sel, 1);
        below_bat = 1'b1;
        step(1);
        chk("R5", "reset floats below battery", r_pull, 0);
        below_bat = 1'b0;
        below_sw = 1'b0;
        step(1);
        chk("R3", "main rail back", b_sel, 0);
        chk("R5", "reset pulled again", r_pull, 1);
        chk("R8", "armed stays set", b_arm, 1);
    endtask

    task automatic t_tolerance();
        tol_wide = 1'b1;
        trip_t = 1'b0;
        trip_w = 1'b1;
        step(REC + 5);
        chk("R2", "wide flag selected keeps protection", s_ce_n, 1);
        tol_wide = 1'b0;
        step(REC + 1);
        chk("R2", "tight flag selected, protected at REC+1", s_ce_n, 1);
        step(1);
        chk("R2", "tight flag selected, released at REC+2", s_ce_n, 0);
        step(RST);
        chk("R2", "unselected wide flag ignored", r_pull, 0);
        trip_w = 1'b0;
    endtask

    task automatic t_dip();
        trip_t = 1'b1;
        step(1);
        trip_t = 1'b0;
        step(REC / 2);
        trip_t = 1'b1;
        step(1);
        chk("R9", "dip restores protection", s_ce_n, 1);
        trip_t = 1'b0;
        step(REC + 1);
        chk("R9", "full window needed after dip", s_ce_n, 1);
        step(1);
        chk("R9", "release after full window", s_ce_n, 0);
        step(RST);
    endtask

    task automatic t_tick_gate();
        trip_t = 1'b1;
        step(1);
        tick = 1'b0;
        trip_t = 1'b0;
        step(REC + 10);
        chk("R10", "count frozen without ticks", s_ce_n, 1);
        tick = 1'b1;
        step(REC);
        chk("R10", "protected until REC ticks", s_ce_n, 1);
        step(1);
        chk("R10", "released after REC ticks", s_ce_n, 0);
        chk("R12", "reset level stays low", r_lvl, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_power_up();
        t_drive_enable();
        t_power_fail();
        t_tolerance();
        t_dip();
        t_tick_gate();
        summary();
    end
endmodule